// File: doc/BRIEF.md
# Event Flag Register with SPI Frame-Length Guard

This block collects event flags from a system-monitor device and makes them readable over a 16-bit SPI slave link. It sees three kinds of source:
- single-cycle event pulses (watchdog time-out, watchdog restart, CAN wake, LIN wake);
- level status inputs, where any change of value is an event;
- supply-detect bits and an active-low wake pin, where only a falling edge is an event.

Every level input passes through a two-stage synchroniser before edge or change detection. The bus pins are sampled in the system clock domain and are oversampled, so the SPI clock must be much slower than the system clock.

A chip-select window counts SPI clock rising edges. Only a window of exactly 16 clocks is acted on:
- A valid access whose two top command bits carry the address code clears the flags it reported.
- If its read-only bit is 0, it also loads the enable register from the command's low twelve bits.
- A window of any other length is discarded and raises a frame-error flag.

The active-low interrupt output is low while any flag is set whose enable bit is also set.

Flag positions, which also form the read-back word and the enable word:
- bit 11: watchdog time-out
- bit 10: temperature change
- bit 9: frame error
- bit 8: ground-shift change
- bit 7: supply loss
- bit 6: reserved, always 0
- bit 5: CAN fault change
- bit 4: LIN fault change
- bit 3: wake pin
- bit 2: watchdog restart
- bit 1: CAN wake
- bit 0: LIN wake

Command word, MSB first:
- bits 15:14: address, `01` selects this register
- bit 13: don't care
- bit 12: read-only
- bits 11:0: enable data

Top module: `sysint_top`

## Requirements
- R1: After reset all flags and all enable bits are 0. irqN is 1 and spiSdo is 0. A first read returns 0x0000.
- R2: During a chip-select-low window, spiSdo shifts out {4'b0000, flags[11:0]}, MSB first. The flags are captured when chip select falls. The master samples each bit before the SCK rising edge, and the next bit follows each SCK falling edge. spiSdo is 0 while spiCsN is high.
- R3: A valid access clears exactly the flags it reported. A valid access has 16 SCK rising edges and bits 15:14 equal to 01.
- R4: An event arriving after the capture is not lost by the clear. This includes an event in the same cycle as the clear. The event is reported by the next read.
- R5: A window with a count other than 16 clears no flag and leaves the enable register unchanged. It sets bit 9. This holds for 15, 17 and zero clocks.
- R6: On a valid access with bit 12 = 0, the enable register takes bits 11:0 of the command, with bit 6 forced to 0. With bit 12 = 1, the enable register is unchanged.
- R7: irqN is 0 exactly when some flag bit and the same enable bit are both 1.
- R8: A change in either direction of tempWarn, gndShift, canFail or linFail, after synchronisation, sets bit 10, 8, 5 or 4 respectively.
- R9: A 1-to-0 transition on any supplyOk bit sets bit 7. A 0-to-1 transition sets nothing.
- R10: A falling edge on wakeN sets bit 3. A rising edge sets nothing.
- R11: A one-cycle high pulse on the following inputs sets the bit shown:
  - wdTimeoutPulse sets bit 11.
  - wdRestartPulse sets bit 2.
  - canWakePulse sets bit 1.
  - linWakePulse sets bit 0.
- R12: Bit 6 of the flags always reads 0, even when every event source is active.
- R13: A 16-clock access whose bits 15:14 differ from 01 clears no flag and leaves the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | SPI clock from the master, idle low |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSdi | input | 1 | SPI serial data in |
| spiSdo | output | 1 | SPI serial data out |
| tempWarn | input | 1 | Temperature warning status level |
| gndShift | input | 1 | Ground-shift status level |
| canFail | input | 1 | CAN fault status level |
| linFail | input | 1 | LIN fault status level |
| supplyOk | input | 3 | Supply-detect status bits, 1 = supply good |
| wakeN | input | 1 | Wake pin, active low |
| wdTimeoutPulse | input | 1 | Watchdog overflow in standby, one-cycle pulse |
| wdRestartPulse | input | 1 | Watchdog restart while off, one-cycle pulse |
| canWakePulse | input | 1 | CAN wake event, one-cycle pulse |
| linWakePulse | input | 1 | LIN wake event, one-cycle pulse |
| irqN | output | 1 | Interrupt request, active low |

## Verification
A corrupted flag register reaches the ports in one of two ways. It appears on irqN within a cycle if the flag is enabled. Otherwise it appears in the next read word, one full frame later. A wrong frame count or a wrong address decode shows up only afterwards: flags survive that should have cleared, or irqN moves after an access that should have been ignored. For that reason every discarded frame is followed by a read and an interrupt check. A lost set-over-clear priority appears as a missing bit in the read that follows the frame during which the event arrived.

// File: rtl/sysint_pkg.sv
package sysint_pkg;
  localparam int FLAG_W = 12;

  localparam int B_LINWAKE = 0;
  localparam int B_CANWAKE = 1;
  localparam int B_WDRST   = 2;
  localparam int B_WAKE    = 3;
  localparam int B_LINFAIL = 4;
  localparam int B_CANFAIL = 5;
  localparam int B_RSVD    = 6;
  localparam int B_SUPPLY  = 7;
  localparam int B_GND     = 8;
  localparam int B_SPIFAIL = 9;
  localparam int B_TEMP    = 10;
  localparam int B_WDTO    = 11;

  typedef struct packed {
    logic active;
    logic shiftIn;
    logic shiftOut;
    logic snap;
    logic accept;
    logic reject;
  } sysint_strobe_t;
endpackage

// File: rtl/sysint_sync.sv
module sysint_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= RST_VAL;
          else       stage[g] <= d;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[g] <= RST_VAL;
          else       stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sysint_ctrl.sv
module sysint_ctrl
  import sysint_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           spiSck,
  input  logic           spiCsN,
  input  logic           spiSdi,
  output sysint_strobe_t strb,
  output logic           sdiBit
);
  localparam int CNT_W = $clog2(FRAME_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_BITS);

  logic [2:0] pinS;
  logic sckS, csS;
  logic sckPrev, csPrev;
  logic [CNT_W-1:0] cntQ;
  logic csRise;

  sysint_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) uPinSync (
    .clk(clk), .rstN(rstN), .d({spiSck, spiCsN, spiSdi}), .q(pinS)
  );

  assign sckS   = pinS[2];
  assign csS    = pinS[1];
  assign sdiBit = pinS[0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
    end

  assign csRise = csS & ~csPrev;

  always_comb begin
    strb.active   = ~csS;
    strb.shiftIn  = ~csS & sckS & ~sckPrev;
    strb.shiftOut = ~csS & ~sckS & sckPrev;
    strb.snap     = ~csS & csPrev;
    strb.accept   = csRise & (cntQ == CNT_GOOD);
    strb.reject   = csRise & (cntQ != CNT_GOOD);
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)
      cntQ <= '0;
    else if (strb.snap)
      cntQ <= strb.shiftIn ? CNT_W'(1) : '0;
    else if (strb.shiftIn && cntQ != CNT_MAX)
      cntQ <= cntQ + 1'b1;
endmodule

// File: rtl/sysint_events.sv
module sysint_events
  import sysint_pkg::*;
#(
  parameter int SUP_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tempWarn,
  input  logic              gndShift,
  input  logic              canFail,
  input  logic              linFail,
  input  logic [SUP_W-1:0]  supplyOk,
  input  logic              wakeN,
  input  logic              wdTimeoutPulse,
  input  logic              wdRestartPulse,
  input  logic              canWakePulse,
  input  logic              linWakePulse,
  output logic [FLAG_W-1:0] evtSet
);
  localparam int LVL_W = 4;

  logic [LVL_W-1:0] lvlS, lvlPrev, lvlChg;
  logic [SUP_W-1:0] supS, supPrev;
  logic wakeS, wakePrev;

  sysint_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) uLvlSync (
    .clk(clk), .rstN(rstN), .d({tempWarn, gndShift, canFail, linFail}), .q(lvlS)
  );
  sysint_sync #(.WIDTH(SUP_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) uSupSync (
    .clk(clk), .rstN(rstN), .d(supplyOk), .q(supS)
  );
  sysint_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uWakeSync (
    .clk(clk), .rstN(rstN), .d(wakeN), .q(wakeS)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      lvlPrev  <= '0;
      supPrev  <= '1;
      wakePrev <= 1'b1;
    end else begin
      lvlPrev  <= lvlS;
      supPrev  <= supS;
      wakePrev <= wakeS;
    end

  assign lvlChg = lvlS ^ lvlPrev;

  always_comb begin
    evtSet            = '0;
    evtSet[B_TEMP]    = lvlChg[3];
    evtSet[B_GND]     = lvlChg[2];
    evtSet[B_CANFAIL] = lvlChg[1];
    evtSet[B_LINFAIL] = lvlChg[0];
    evtSet[B_SUPPLY]  = |(supPrev & ~supS);
    evtSet[B_WAKE]    = wakePrev & ~wakeS;
    evtSet[B_WDTO]    = wdTimeoutPulse;
    evtSet[B_WDRST]   = wdRestartPulse;
    evtSet[B_CANWAKE] = canWakePulse;
    evtSet[B_LINWAKE] = linWakePulse;
  end
endmodule

// File: rtl/sysint_data.sv
module sysint_data
  import sysint_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter logic [1:0] ADDR_VAL = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  sysint_strobe_t    strb,
  input  logic              sdiBit,
  input  logic [FLAG_W-1:0] evtSet,
  output logic [FLAG_W-1:0] flagQ,
  output logic [FLAG_W-1:0] enQ,
  output logic              sdoBit
);
  localparam int MSB = FRAME_BITS - 1;
  localparam int RO_POS = FRAME_BITS - 4;
  localparam int PAD_W = FRAME_BITS - FLAG_W;
  localparam logic [FLAG_W-1:0] RSVD_MASK = FLAG_W'(1) << B_RSVD;

  logic [MSB:0] shIn, shOut;
  logic [FLAG_W-1:0] snapQ, clearMask, setAll, flagNext;
  logic addrOk, ownAccess;

  assign addrOk    = (shIn[MSB:MSB-1] == ADDR_VAL);
  assign ownAccess = strb.accept & addrOk;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) shIn <= '0;
    else if (strb.shiftIn) shIn <= {shIn[MSB-1:0], sdiBit};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      shOut <= '0;
      snapQ <= '0;
    end else if (strb.snap) begin
      shOut <= {{PAD_W{1'b0}}, flagQ};
      snapQ <= flagQ;
    end else if (strb.shiftOut) begin
      shOut <= {shOut[MSB-1:0], 1'b0};
    end

  assign sdoBit = strb.active & shOut[MSB];

  always_comb begin
    clearMask = ownAccess ? snapQ : '0;
    setAll = evtSet;
    setAll[B_SPIFAIL] = evtSet[B_SPIFAIL] | strb.reject;
    flagNext = ((flagQ & ~clearMask) | setAll) & ~RSVD_MASK;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) enQ <= '0;
    else if (ownAccess && !shIn[RO_POS]) enQ <= shIn[FLAG_W-1:0] & ~RSVD_MASK;
endmodule

// File: rtl/sysint_top.sv
module sysint_top
  import sysint_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int SUP_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiSck,
  input  logic             spiCsN,
  input  logic             spiSdi,
  output logic             spiSdo,
  input  logic             tempWarn,
  input  logic             gndShift,
  input  logic             canFail,
  input  logic             linFail,
  input  logic [SUP_W-1:0] supplyOk,
  input  logic             wakeN,
  input  logic             wdTimeoutPulse,
  input  logic             wdRestartPulse,
  input  logic             canWakePulse,
  input  logic             linWakePulse,
  output logic             irqN
);
  sysint_strobe_t strb;
  logic sdiBit;
  logic [FLAG_W-1:0] evtSet, flagQ, enQ;

  sysint_ctrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSdi(spiSdi),
    .strb(strb), .sdiBit(sdiBit)
  );

  sysint_events #(.SUP_W(SUP_W), .SYNC_STAGES(SYNC_STAGES)) uEvents (
    .clk(clk), .rstN(rstN), .tempWarn(tempWarn), .gndShift(gndShift),
    .canFail(canFail), .linFail(linFail), .supplyOk(supplyOk), .wakeN(wakeN),
    .wdTimeoutPulse(wdTimeoutPulse), .wdRestartPulse(wdRestartPulse),
    .canWakePulse(canWakePulse), .linWakePulse(linWakePulse), .evtSet(evtSet)
  );

  sysint_data #(.FRAME_BITS(FRAME_BITS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiBit(sdiBit), .evtSet(evtSet),
    .flagQ(flagQ), .enQ(enQ), .sdoBit(spiSdo)
  );

  assign irqN = ~|(flagQ & enQ);
endmodule

// File: rtl/sysint_chk.sv
module sysint_chk
  import sysint_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input sysint_strobe_t    strb,
  input logic [FLAG_W-1:0] flagQ,
  input logic [FLAG_W-1:0] enQ,
  input logic              wdTimeoutPulse
);
  // R5: a discarded window raises the frame-error flag
  a_r5_bad_frame_flag: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> flagQ[B_SPIFAIL]);

  // R5: a discarded window leaves the enable register alone
  a_r5_bad_frame_keeps_enable: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> $stable(enQ));

  // R4: a new event wins over a clear in the same cycle
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeoutPulse |=> flagQ[B_WDTO]);

  // R3: flags only fall after an accepted access
  a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R12: the reserved position never holds a 1
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    !flagQ[B_RSVD] && !enQ[B_RSVD]);
endmodule

bind sysint_top sysint_chk uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .flagQ(flagQ), .enQ(enQ),
  .wdTimeoutPulse(wdTimeoutPulse)
);

// File: tb/sysint_top_test.sv
module sysint_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSck = 1'b0, spiCsN = 1'b1, spiSdi = 1'b0;
  logic spiSdo, irqN;
  logic tempWarn = 0, gndShift = 0, canFail = 0, linFail = 0;
  logic [2:0] supplyOk = 3'b111;
  logic wakeN = 1'b1;
  logic wdTimeoutPulse = 0, wdRestartPulse = 0, canWakePulse = 0, linWakePulse = 0;

  int nCmp = 0;
  int nBad = 0;

  typedef struct {
    logic [15:0] val;
    string tag;
  } exp_t;
  exp_t expQ[$];
  logic [15:0] actQ[$];

  always #4 clk = ~clk;

  sysint_top uut (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSdi(spiSdi),
    .spiSdo(spiSdo), .tempWarn(tempWarn), .gndShift(gndShift), .canFail(canFail),
    .linFail(linFail), .supplyOk(supplyOk), .wakeN(wakeN),
    .wdTimeoutPulse(wdTimeoutPulse), .wdRestartPulse(wdRestartPulse),
    .canWakePulse(canWakePulse), .linWakePulse(linWakePulse), .irqN(irqN)
  );

  task automatic checkBit(input logic act, input logic expv, input string tag);
    nCmp++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic spiXfer(input logic [15:0] cmd, input int nClk, input bit midEvt,
                         output logic [15:0] rd);
    rd = '0;
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nClk; i++) begin
      spiSdi = (i < 16) ? cmd[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      if (i < 16) rd[15-i] = spiSdo;
      spiSck = 1'b1;
      repeat (8) @(negedge clk);
      spiSck = 1'b0;
      if (midEvt && i == 8) begin
        wdTimeoutPulse = 1'b1;
        @(negedge clk);
        wdTimeoutPulse = 1'b0;
      end
    end
    repeat (8) @(negedge clk);
    spiCsN = 1'b1;
    spiSdi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic expectRead(input logic [15:0] cmd, input logic [15:0] expv,
                            input string tag, input bit midEvt = 1'b0);
    logic [15:0] rd;
    exp_t e;
    e.val = expv;
    e.tag = tag;
    expQ.push_back(e);
    spiXfer(cmd, 16, midEvt, rd);
    actQ.push_back(rd);
  endtask

  task automatic badFrame(input logic [15:0] cmd, input int nClk);
    logic [15:0] rd;
    spiXfer(cmd, nClk, 1'b0, rd);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: linWakePulse = 1'b1;
      1: canWakePulse = 1'b1;
      2: wdRestartPulse = 1'b1;
      default: wdTimeoutPulse = 1'b1;
    endcase
    @(negedge clk);
    linWakePulse = 0; canWakePulse = 0; wdRestartPulse = 0; wdTimeoutPulse = 0;
  endtask

  function automatic logic [15:0] rdCmd();
    return 16'h5000;
  endfunction

  function automatic logic [15:0] wrCmd(input logic [11:0] en);
    return {4'b0100, en};
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        exp_t e;
        logic [15:0] a;
        e = expQ.pop_front();
        a = actQ.pop_front();
        nCmp++;
        if (a !== e.val) begin
          nBad++;
          $display("FAIL %s: actual %h expected %h", e.tag, a, e.val);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin : stimulus
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    settle();
    checkBit(irqN, 1'b1, "R1 irqN after reset");
    checkBit(spiSdo, 1'b0, "R1 sdo after reset");
    expectRead(rdCmd(), 16'h0000, "R1 first read");
    checkBit(spiSdo, 1'b0, "R2 sdo low with cs high");

    pulse(3); pulse(1); settle();
    expectRead(rdCmd(), 16'h0802, "R11 R2 timeout and can wake");
    expectRead(rdCmd(), 16'h0000, "R3 cleared after read");
    pulse(2); pulse(0); settle();
    expectRead(rdCmd(), 16'h0005, "R11 restart and lin wake");

    tempWarn = 1; settle();
    expectRead(rdCmd(), 16'h0400, "R8 temp rise");
    tempWarn = 0; gndShift = 1; settle();
    expectRead(rdCmd(), 16'h0500, "R8 temp fall and gnd rise");
    canFail = 1; linFail = 1; settle();
    expectRead(rdCmd(), 16'h0030, "R8 can and lin fault");

    supplyOk[1] = 0; settle();
    expectRead(rdCmd(), 16'h0080, "R9 supply loss");
    supplyOk[1] = 1; settle();
    expectRead(rdCmd(), 16'h0000, "R9 supply return");
    wakeN = 0; settle();
    expectRead(rdCmd(), 16'h0008, "R10 wake fall");
    wakeN = 1; settle();
    expectRead(rdCmd(), 16'h0000, "R10 wake rise");

    pulse(1); settle();
    badFrame(wrCmd(12'hFFF), 15);
    checkBit(irqN, 1'b1, "R5 15-clock frame no enable write");
    expectRead(rdCmd(), 16'h0202, "R5 15-clock frame no clear");
    badFrame(wrCmd(12'hFFF), 17);
    checkBit(irqN, 1'b1, "R5 17-clock frame no enable write");
    expectRead(rdCmd(), 16'h0200, "R5 17-clock frame flagged");
    badFrame(wrCmd(12'hFFF), 0);
    expectRead(rdCmd(), 16'h0200, "R5 zero-clock frame flagged");

    expectRead(wrCmd(12'h002), 16'h0000, "R6 write enable");
    checkBit(irqN, 1'b1, "R6 irq idle with no flag");
    pulse(1); settle();
    checkBit(irqN, 1'b0, "R7 enabled flag asserts irq");
    expectRead(rdCmd(), 16'h0002, "R7 read enabled flag");
    checkBit(irqN, 1'b1, "R7 irq released after clear");
    pulse(0); settle();
    checkBit(irqN, 1'b1, "R7 disabled flag no irq");
    expectRead(rdCmd(), 16'h0001, "R7 disabled flag readable");

    expectRead(16'h5FFF, 16'h0000, "R6 read-only access");
    pulse(3); settle();
    checkBit(irqN, 1'b1, "R6 enable unchanged by read-only");
    expectRead(rdCmd(), 16'h0800, "R6 timeout flag");

    pulse(0); settle();
    begin
      logic [15:0] rd;
      spiXfer(16'h8001, 16, 1'b0, rd);
    end
    checkBit(irqN, 1'b1, "R13 other address no enable write");
    expectRead(rdCmd(), 16'h0001, "R13 other address no clear");

    expectRead(rdCmd(), 16'h0000, "R4 frame with mid event", 1'b1);
    expectRead(rdCmd(), 16'h0800, "R4 mid-frame event kept");

    expectRead(wrCmd(12'hFFF), 16'h0000, "R12 enable all");
    tempWarn = 1; gndShift = 0; canFail = 0; linFail = 0;
    supplyOk[0] = 0; wakeN = 0;
    pulse(0); pulse(1); pulse(2); pulse(3); settle();
    checkBit(irqN, 1'b0, "R7 irq with all enabled");
    badFrame(rdCmd(), 15);
    expectRead(rdCmd(), 16'h0FBF, "R12 all sources, bit 6 zero");
    checkBit(irqN, 1'b1, "R3 irq released after full clear");

    while (actQ.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule